// File: doc/BRIEF.md
# Two-Group Pin Change Interrupt Controller

This block watches twelve input pins and raises an interrupt request when any selected pin toggles. The pins are split into two groups. Pins 0 to 7 form group 0 and pins 8 to 11 form group 1. Each pin has its own select bit. Each group has an enable bit, a sticky event flag and a request output.

Each input passes through a two-flop synchronizer. An edge is found by comparing the synchronized value with its value one cycle earlier. A rising or a falling change on any selected pin of a group sets that group's flag. The flag stays set until software clears it, either by writing a one to its flag bit or by pulsing the group's acknowledge input. A group's request is driven only while its flag, its enable and the global interrupt-enable input are all high. If a new change lands in the same cycle as a clear, the change wins, so no event is lost.

Software reaches the block through a small register port. Writes are synchronous and reads are combinational.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset, all four registers read as zero and both request outputs are low.
- R2: Register map, with reads combinational from `reg_addr_i`:
  - Address 0 is the 8-bit group-0 select mask. Bit n selects pin n.
  - Address 1 is the group-1 select mask. Bit n selects pin 8+n. Only bits 3:0 are stored, and the upper bits read as zero.
  - Address 2 holds the group enables: bit 0 for group 0, bit 1 for group 1. The other bits read as zero.
  - Address 3 holds the flags: bit 0 for group 0, bit 1 for group 1.
- R3: A change in either direction on a selected pin sets its group flag. The flag is visible on the third rising clock edge after the pin changes.
- R4: A change on a pin whose select bit is clear leaves both flags clear.
- R5: Pins 0 to 7 only ever set flag bit 0, and pins 8 to 11 only ever set flag bit 1.
- R6: `irq_o[g]` is high exactly when flag g, enable bit g and `gie_i` are all high. Changing the enable or `gie_i` does not alter the flags.
- R7: Writing address 3 clears each flag whose write-data bit is one. A zero bit leaves that flag unchanged.
- R8: A one-cycle pulse on `ack_i[g]` clears flag g at that clock edge.
- R9: If a selected-pin change reaches the flag logic in the same cycle as an acknowledge or a write-one clear, the flag ends up set.
- R10: A set flag stays set, with no further pin activity, until it is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pins_i | input | 12 | Watched pins, group 0 in bits 7:0, group 1 in bits 11:8 |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 2 | Per-group acknowledge (auto clear of the flag) |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data |
| irq_o | output | 2 | Per-group interrupt request |

## Verification
A detected pin change and a flag clear can land in the same clock cycle. The clear can be an acknowledge pulse or a write-one to the flag register. The bench provokes this by toggling a selected pin and then timing the clear to the cycle in which the synchronized edge reaches the flag logic, which is two rising edges after the pin change. The collision passes only if the flag reads one afterwards. A control case, an acknowledge with no pin activity, must leave the flag zero.

// File: rtl/pcint_pkg.sv
package pcint_pkg;
  localparam int NUM_GROUPS = 2;
  localparam int REG_AW     = 2;

  localparam logic [REG_AW-1:0] ADDR_MASK0 = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_MASK1 = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_EN    = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_FLAG  = 2'd3;
endpackage

// File: rtl/pcint_sync.sv
module pcint_sync #(
  parameter int W      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] stage_q [STAGES];
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  // any-direction change of the synchronized value
  assign edge_o = stage_q[STAGES-1] ^ prev_q;
endmodule

// File: rtl/pcint_group.sv
module pcint_group #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] edge_i,
  input  logic [W-1:0] mask_i,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic         gie_i,
  output logic         set_o,
  output logic         flag_o,
  output logic         irq_o
);
  logic flag_q;

  assign set_o = |(edge_i & mask_i);

  // set dominates clear so a colliding event survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_o | (flag_q & ~clr_i);
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q & en_i & gie_i;
endmodule

// File: rtl/pcint_regs.sv
module pcint_regs
  import pcint_pkg::*;
#(
  parameter int G0W  = 8,
  parameter int G1W  = 4,
  parameter int MAXW = 8,
  parameter int DW   = 8
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_AW-1:0]     addr_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic [NUM_GROUPS-1:0] flags_i,
  output logic [DW-1:0]         rdata_o,
  output logic [MAXW-1:0]       mask_o [NUM_GROUPS],
  output logic [NUM_GROUPS-1:0] en_o,
  output logic [NUM_GROUPS-1:0] flag_w1c_o
);
  localparam int GRP_W [NUM_GROUPS] = '{G0W, G1W};

  logic [MAXW-1:0]       mask_q [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] en_q;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_mask
    localparam logic [MAXW-1:0] KEEP = {MAXW{1'b1}} >> (MAXW - GRP_W[g]);
    localparam logic [REG_AW-1:0] MADDR = (g == 0) ? ADDR_MASK0 : ADDR_MASK1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     mask_q[g] <= '0;
      else if (we_i && addr_i == MADDR) mask_q[g] <= wdata_i[MAXW-1:0] & KEEP;
    end

    assign mask_o[g] = mask_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_q <= '0;
    else if (we_i && addr_i == ADDR_EN) en_q <= wdata_i[NUM_GROUPS-1:0];
  end

  assign en_o       = en_q;
  assign flag_w1c_o = (we_i && addr_i == ADDR_FLAG) ? wdata_i[NUM_GROUPS-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_MASK0: rdata_o = DW'(mask_q[0]);
      ADDR_MASK1: rdata_o = DW'(mask_q[1]);
      ADDR_EN:    rdata_o = DW'(en_q);
      default:    rdata_o = DW'(flags_i);
    endcase
  end
endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
  import pcint_pkg::*;
#(
  parameter int G0_PINS     = 8,
  parameter int G1_PINS     = 4,
  parameter int SYNC_STAGES = 2,
  parameter int DATA_W      = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [G0_PINS+G1_PINS-1:0]    pins_i,
  input  logic                          gie_i,
  input  logic [NUM_GROUPS-1:0]         ack_i,
  input  logic                          reg_we_i,
  input  logic [REG_AW-1:0]             reg_addr_i,
  input  logic [DATA_W-1:0]             reg_wdata_i,
  output logic [DATA_W-1:0]             reg_rdata_o,
  output logic [NUM_GROUPS-1:0]         irq_o
);
  localparam int NPINS = G0_PINS + G1_PINS;
  localparam int MAXW  = (G0_PINS > G1_PINS) ? G0_PINS : G1_PINS;
  localparam int GRP_BASE [NUM_GROUPS] = '{0, G0_PINS};

  logic [NPINS-1:0]      pin_edge;
  logic [NPINS+MAXW-1:0] edge_pad;
  logic [MAXW-1:0]       grp_mask [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_en, grp_w1c, grp_set, grp_flag;

  pcint_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pins_i),
    .edge_o (pin_edge)
  );

  assign edge_pad = {{MAXW{1'b0}}, pin_edge};

  pcint_regs #(.G0W(G0_PINS), .G1W(G1_PINS), .MAXW(MAXW), .DW(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flags_i    (grp_flag),
    .rdata_o    (reg_rdata_o),
    .mask_o     (grp_mask),
    .en_o       (grp_en),
    .flag_w1c_o (grp_w1c)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    pcint_group #(.W(MAXW)) u_grp (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .edge_i (edge_pad[GRP_BASE[g] +: MAXW]),
      .mask_i (grp_mask[g]),
      .clr_i  (grp_w1c[g] | ack_i[g]),
      .en_i   (grp_en[g]),
      .gie_i  (gie_i),
      .set_o  (grp_set[g]),
      .flag_o (grp_flag[g]),
      .irq_o  (irq_o[g])
    );
  end
endmodule

// File: rtl/pcint_ctrl_chk.sv
module pcint_ctrl_chk
  import pcint_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  gie_i,
  input logic [NUM_GROUPS-1:0] ack_i,
  input logic                  reg_we_i,
  input logic [REG_AW-1:0]     reg_addr_i,
  input logic [DATA_W-1:0]     reg_wdata_i,
  input logic [NUM_GROUPS-1:0] irq_o,
  input logic [NUM_GROUPS-1:0] flag,
  input logic [NUM_GROUPS-1:0] set
);
  logic flag_wr;
  assign flag_wr = reg_we_i && reg_addr_i == ADDR_FLAG;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    // R6
    irq_needs_gie_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[g] |-> gie_i && flag[g]);
    // R3
    set_reaches_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[g] |=> flag[g]);
    // R3
    rise_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(flag[g]) |-> $past(set[g]));
    // R8
    ack_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[g] && !set[g]) |=> !flag[g]);
    // R7
    w1c_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_wr && reg_wdata_i[g] && !set[g]) |=> !flag[g]);
    // R10
    sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag[g] && !ack_i[g] && !(flag_wr && reg_wdata_i[g])) |=> flag[g]);
    // R9
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set[g] && (ack_i[g] || (flag_wr && reg_wdata_i[g]))) |=> flag[g]);
  end
endmodule

bind pcint_ctrl pcint_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .gie_i       (gie_i),
  .ack_i       (ack_i),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .irq_o       (irq_o),
  .flag        (grp_flag),
  .set         (grp_set)
);

// File: tb/pcint_ctrl_tb.sv
module pcint_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] pins = '0;
  logic        gie = 1'b0;
  logic [1:0]  ack = '0;
  logic        we = 1'b0;
  logic [1:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pcint_ctrl u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .gie_i       (gie),
    .ack_i       (ack),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic check(input int got, input int exp, input string req);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    addr = a;
    #1;
    v = int'(rdata);
  endtask

  task automatic toggle(input int i);
    @(negedge clk);
    pins[i] = ~pins[i];
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      check(v, 0, "R1 reg");
    end
    check(int'(irq), 0, "R1 irq");

    // R2 register map
    wr(2'd0, 8'hA5); rd(2'd0, v); check(v, 'hA5, "R2 mask0");
    wr(2'd1, 8'hFF); rd(2'd1, v); check(v, 'h0F, "R2 mask1");
    wr(2'd2, 8'hFF); rd(2'd2, v); check(v, 'h03, "R2 en");

    // R3 R4 R5 sweep: each pin toggled against each single-pin mask
    gie = 1'b1;
    for (int j = 0; j < 12; j++) begin
      for (int i = 0; i < 12; i++) begin
        int exp;
        wr(2'd0, (j < 8) ? 8'(1 << j) : 8'h00);
        wr(2'd1, (j >= 8) ? 8'(1 << (j - 8)) : 8'h00);
        wr(2'd3, 8'h03);
        toggle(i);
        exp = (i == j) ? ((i < 8) ? 1 : 2) : 0;
        rd(2'd3, v);
        if (i == j) check(v, exp, "R3 R5 flag");
        else        check(v, exp, "R4 unmasked");
        check(int'(irq), exp, "R6 irq sweep");
      end
    end

    // R10 sticky
    wr(2'd0, 8'hFF); wr(2'd1, 8'h0F); wr(2'd3, 8'h03);
    toggle(0); toggle(8);
    repeat (10) @(negedge clk);
    rd(2'd3, v); check(v, 3, "R10 sticky");

    // R6 gating over enables and gie
    for (int e = 0; e < 4; e++) begin
      for (int gv = 0; gv < 2; gv++) begin
        wr(2'd2, 8'(e));
        gie = gv[0];
        #1;
        check(int'(irq), gv ? e : 0, "R6 gate");
        rd(2'd3, v); check(v, 3, "R6 flags kept");
      end
    end
    gie = 1'b1;
    wr(2'd2, 8'h03);

    // R7 write-one clear
    wr(2'd3, 8'h00); rd(2'd3, v); check(v, 3, "R7 write zero");
    wr(2'd3, 8'h01); rd(2'd3, v); check(v, 2, "R7 clear g0");
    wr(2'd3, 8'h02); rd(2'd3, v); check(v, 0, "R7 clear g1");

    // R8 acknowledge
    toggle(5); toggle(10);
    @(negedge clk); ack = 2'b01; @(posedge clk); @(negedge clk); ack = '0;
    rd(2'd3, v); check(v, 2, "R8 ack g0");
    ack = 2'b10; @(posedge clk); @(negedge clk); ack = '0;
    rd(2'd3, v); check(v, 0, "R8 ack g1");

    // R9 collision with acknowledge
    @(negedge clk); pins[3] = ~pins[3];
    repeat (2) @(posedge clk);
    @(negedge clk); ack = 2'b01;
    @(posedge clk); @(negedge clk); ack = '0;
    rd(2'd3, v); check(v, 1, "R9 ack collision");
    // control: acknowledge alone clears
    ack = 2'b01; @(posedge clk); @(negedge clk); ack = '0;
    rd(2'd3, v); check(v, 0, "R8 ack control");

    // R9 collision with write-one
    @(negedge clk); pins[9] = ~pins[9];
    repeat (2) @(posedge clk);
    @(negedge clk); we = 1'b1; addr = 2'd3; wdata = 8'h02;
    @(posedge clk); @(negedge clk); we = 1'b0; wdata = '0;
    rd(2'd3, v); check(v, 2, "R9 w1c collision");
    check(int'(irq), 2, "R6 irq after collision");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule